// File: doc/BRIEF.md
# Ethernet Receive Frame Front End

This block sits between a recovered serial receive stream and the receive transfer engine. On each rising edge of the receive clock it samples one data bit together with carrier sense. While carrier is present and no frame is open, it slides every bit through an 8-bit window and looks for the start-of-frame delimiter. Preamble bits are thrown away. Once the delimiter is found, the block declares a frame valid and empties its octet FIFO. It then packs every following bit into octets, least significant bit first, and writes them into that FIFO.

The first six octets form the destination address. They are compared against a programmable station address and against the all-ones broadcast address. During that comparison the transfer enable and the burst request stay low. On a match the transfer enable rises, and a burst request is raised whenever the FIFO holds at least the programmed burst threshold. On a mismatch the FIFO is emptied, no further octets are written, and the block waits for the next delimiter.

When carrier drops, the frame closes. The block then counts three further receive clocks to let end-of-frame processing settle, and finally pulses a done indication. A downstream reader drains the FIFO through a show-ahead read port.

Top module: `eth_rx_front`

## Requirements
- R1: No bit received before or during the preamble is ever written to the FIFO: while `frame_valid` is low the FIFO level never increases.
- R2: The delimiter is the octet 0xD5 sent least significant bit first (serial order 1,0,1,0,1,0,1,1). `frame_valid` is high in the cycle after the edge that samples the delimiter's last bit, and the FIFO level is 0 at that point, with any earlier contents discarded.
- R3: Octets start with the first bit after the delimiter. The first bit received is bit 0 of the octet. Each octet is written on the edge that samples its eighth bit, and `rd_data` shows the oldest stored octet.
- R4: From the delimiter until the edge that completes the sixth destination octet, `xfer_en` and `burst_req` are low. `xfer_en` is also cleared at every delimiter.
- R5: On an address match, `xfer_en` is high after the sixth destination octet. `burst_req` is high whenever `xfer_en` is high and `fifo_level` is at least `burst_thresh` (valid thresholds are 1 to FIFO depth).
- R6: On an address mismatch, the FIFO is emptied at the sixth destination octet, later octets of that frame are not written, and `xfer_en` stays low.
- R7: A destination address matches if all six octets equal `station_addr`, where octet k (k=0 first on the wire) is bits [8k+7:8k]. It also matches if all six octets are 0xFF.
- R8: Source address, length/type and payload octets are stored unchanged with no interpretation. A payload octet equal to 0xD5 neither restarts the frame nor empties the FIFO.
- R9: `frame_valid` falls after the first edge that samples `rx_crs` low. `frame_done` is high for exactly one cycle, following the third further edge. Bits of an incomplete trailing octet are discarded.
- R10: After an accepted frame is done, `xfer_en` stays high until the next delimiter, and `burst_req` stays high while the FIFO is not empty, even below the threshold.
- R11: Carrier loss during the preamble opens no frame and gives no `frame_done`. A frame that ends inside the destination address never raises `xfer_en` but still gives `frame_done`.
- R12: After reset all outputs are low and the FIFO is empty. A read request on an empty FIFO leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; one serial bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_crs | input | 1 | Carrier sense |
| rx_bit | input | 1 | Serial receive data bit |
| station_addr | input | 48 | Station unicast address, octet k in bits [8k+7:8k] |
| burst_thresh | input | LVL_W (5) | FIFO fill level that raises a burst request |
| rd_en | input | 1 | Read request; pops the head octet |
| rd_data | output | 8 | Oldest stored octet (show-ahead) |
| fifo_level | output | LVL_W (5) | Number of octets stored |
| frame_valid | output | 1 | High from delimiter until carrier loss |
| xfer_en | output | 1 | Downstream transfer enabled for the current frame |
| burst_req | output | 1 | Request for a burst transfer |
| frame_done | output | 1 | One-cycle pulse when end-of-frame processing completes |

## Verification
The in-RTL assertions watch, on every cycle, several properties. The FIFO never fills while no frame is open. The FIFO is empty and transfer is held off at the moment a frame opens. A rejected frame keeps the FIFO empty. The done pulse comes exactly three clocks after the frame-valid fall. The directed scenarios must show the parts that depend on data content. These are least-significant-bit-first packing and byte-for-byte passthrough, unicast versus broadcast versus single-octet mismatch, the threshold crossing point, and the drain rule after the frame ends. They also cover aborted preambles, truncated address fields and the discarded trailing bits.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
    localparam logic [7:0] SFD_OCTET = 8'hD5;
    localparam int         DA_OCTETS = 6;
    localparam int         IDX_W     = $clog2(DA_OCTETS);
    localparam int         TAIL_CLKS = 3;
    localparam int         TAIL_W    = $clog2(TAIL_CLKS + 1);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ADDR,
        ST_PASS,
        ST_DROP,
        ST_TAIL
    } rx_state_e;
endpackage

// File: rtl/eth_rx_deser.sv
module eth_rx_deser
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       shift_en,
    input  logic       clear_all,
    input  logic       clear_cnt,
    output logic [7:0] octet_next,
    output logic       octet_done,
    output logic       sfd_hit
);
    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] cnt;
    } deser_t;

    deser_t q, d;

    always_comb begin
        octet_next = {rx_bit, q.sh[7:1]};
        octet_done = shift_en && (q.cnt == 3'd7);
        sfd_hit    = shift_en && (octet_next == SFD_OCTET);
        d = q;
        if (clear_all) begin
            d = '0;
        end else if (shift_en) begin
            d.sh  = octet_next;
            d.cnt = clear_cnt ? 3'd0 : q.cnt + 3'd1;
        end else if (clear_cnt) begin
            d.cnt = 3'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/eth_rx_addr_match.sv
module eth_rx_addr_match
    import eth_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             octet_valid,
    input  logic [IDX_W-1:0] octet_idx,
    input  logic [7:0]       octet,
    input  logic [47:0]      station_addr,
    output logic             match_now
);
    typedef struct packed {
        logic uc_ok;
        logic bc_ok;
    } match_t;

    match_t     q, d;
    logic [7:0] st_octet;
    logic       eq_uc, eq_bc;

    always_comb begin
        st_octet  = station_addr[8*octet_idx +: 8];
        eq_uc     = (octet == st_octet);
        eq_bc     = (octet == 8'hFF);
        match_now = (q.uc_ok && eq_uc) || (q.bc_ok && eq_bc);
        d = q;
        if (start) begin
            d.uc_ok = 1'b1;
            d.bc_ok = 1'b1;
        end else if (octet_valid) begin
            d.uc_ok = q.uc_ok && eq_uc;
            d.bc_ok = q.bc_ok && eq_bc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/eth_rx_fifo.sv
module eth_rx_fifo #(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       wdata,
    input  logic             pop,
    output logic [7:0]       rdata,
    output logic [LVL_W-1:0] level
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] cnt;
    } ptr_t;

    ptr_t       q, d;
    logic [7:0] mem [DEPTH];
    logic       do_push, do_pop, full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (q.cnt == LVL_W'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (!full || do_pop);
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wr = bump(q.wr);
            if (do_pop)  d.rd = bump(q.rd);
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[q.wr] <= wdata;
    end

    assign rdata = mem[q.rd];
    assign level = q.cnt;
endmodule

// File: rtl/eth_rx_front.sv
module eth_rx_front
    import eth_rx_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_crs,
    input  logic             rx_bit,
    input  logic [47:0]      station_addr,
    input  logic [LVL_W-1:0] burst_thresh,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [LVL_W-1:0] fifo_level,
    output logic             frame_valid,
    output logic             xfer_en,
    output logic             burst_req,
    output logic             frame_done
);
    localparam logic [IDX_W-1:0]  DA_LAST  = IDX_W'(DA_OCTETS - 1);
    localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(TAIL_CLKS - 1);

    typedef struct packed {
        rx_state_e         state;
        logic              fv;
        logic              xfer;
        logic              drain;
        logic              done;
        logic [IDX_W-1:0]  da_idx;
        logic [TAIL_W-1:0] tail_cnt;
    } ctl_t;

    ctl_t       q, d;
    logic       shift_en, clear_all, sfd_take, addr_octet;
    logic [7:0] octet_next;
    logic       octet_done, sfd_hit, addr_match;
    logic       push, flush;

    assign shift_en   = rx_crs && (q.state != ST_TAIL);
    assign clear_all  = (q.state == ST_TAIL) || (q.state == ST_HUNT && !rx_crs);
    assign sfd_take   = (q.state == ST_HUNT) && sfd_hit;
    assign addr_octet = (q.state == ST_ADDR) && rx_crs && octet_done;

    eth_rx_deser u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .shift_en   (shift_en),
        .clear_all  (clear_all),
        .clear_cnt  (sfd_take),
        .octet_next (octet_next),
        .octet_done (octet_done),
        .sfd_hit    (sfd_hit)
    );

    eth_rx_addr_match u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (sfd_take),
        .octet_valid  (addr_octet),
        .octet_idx    (q.da_idx),
        .octet        (octet_next),
        .station_addr (station_addr),
        .match_now    (addr_match)
    );

    eth_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .wdata (octet_next),
        .pop   (rd_en),
        .rdata (rd_data),
        .level (fifo_level)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        push   = 1'b0;
        flush  = 1'b0;
        unique case (q.state)
            ST_HUNT: begin
                if (sfd_take) begin
                    flush    = 1'b1;
                    d.state  = ST_ADDR;
                    d.fv     = 1'b1;
                    d.xfer   = 1'b0;
                    d.drain  = 1'b0;
                    d.da_idx = '0;
                end
            end
            ST_ADDR, ST_PASS, ST_DROP: begin
                if (!rx_crs) begin
                    d.state    = ST_TAIL;
                    d.fv       = 1'b0;
                    d.tail_cnt = '0;
                end else if (octet_done) begin
                    push = (q.state != ST_DROP);
                    if (q.state == ST_ADDR) begin
                        d.da_idx = q.da_idx + 1'b1;
                        if (q.da_idx == DA_LAST) begin
                            if (addr_match) begin
                                d.state = ST_PASS;
                                d.xfer  = 1'b1;
                            end else begin
                                d.state = ST_DROP;
                                flush   = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_TAIL: begin
                d.tail_cnt = q.tail_cnt + 1'b1;
                if (q.tail_cnt == TAIL_END) begin
                    d.state = ST_HUNT;
                    d.done  = 1'b1;
                    d.drain = q.xfer;
                end
            end
            default: d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    assign frame_valid = q.fv;
    assign xfer_en     = q.xfer;
    assign frame_done  = q.done;
    assign burst_req   = q.xfer && (fifo_level != '0) &&
                         ((fifo_level >= burst_thresh) || q.drain);

    assert_no_fill_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> fifo_level <= $past(fifo_level));

    assert_flush_on_sfd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> fifo_level == '0);

    assert_hold_at_sfd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> !xfer_en && !burst_req);

    assert_drop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DROP) |-> (fifo_level == '0) && !xfer_en);

    assert_tail_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !$past(frame_valid, 3) && $past(frame_valid, 4));
endmodule

// File: tb/eth_rx_front_tb.sv
module eth_rx_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_crs = 1'b0;
    logic          rx_bit = 1'b0;
    logic [47:0]   station_addr = 48'hAB_89_67_45_23_02;
    logic [LW-1:0] burst_thresh = LW'(8);
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [LW-1:0] fifo_level;
    logic          frame_valid, xfer_en, burst_req, frame_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] fr [0:15];

    always #(CLK_PERIOD / 2) clk = ~clk;

    eth_rx_front #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_crs       (rx_crs),
        .rx_bit       (rx_bit),
        .station_addr (station_addr),
        .burst_thresh (burst_thresh),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .fifo_level   (fifo_level),
        .frame_valid  (frame_valid),
        .xfer_en      (xfer_en),
        .burst_req    (burst_req),
        .frame_done   (frame_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic c, input logic b);
        @(negedge clk);
        rx_crs = c;
        rx_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_preamble(input int nbits);
        for (int i = 0; i < nbits; i++) bit_cycle(1'b1, (i % 2) == 0);
    endtask

    task automatic send_octet(input logic [7:0] v);
        for (int i = 0; i < 8; i++) bit_cycle(1'b1, v[i]);
    endtask

    task automatic open_frame();
        send_preamble(56);
        chk("R1 no frame during preamble", frame_valid, 0);
        send_octet(8'hD5);
        chk("R2 frame_valid after delimiter", frame_valid, 1);
        chk("R2 fifo emptied at delimiter", fifo_level, 0);
        chk("R4 xfer held at delimiter", xfer_en, 0);
        chk("R4 burst held at delimiter", burst_req, 0);
    endtask

    task automatic end_carrier();
        bit_cycle(1'b0, 1'b0);
        chk("R9 frame_valid falls on carrier loss", frame_valid, 0);
        chk("R9 no done yet", frame_done, 0);
        for (int i = 0; i < 2; i++) begin
            bit_cycle(1'b0, 1'b0);
            chk("R9 no done during tail", frame_done, 0);
        end
        bit_cycle(1'b0, 1'b0);
        chk("R9 done after three tail clocks", frame_done, 1);
        bit_cycle(1'b0, 1'b0);
        chk("R9 done lasts one cycle", frame_done, 0);
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12 reset frame_valid", frame_valid, 0);
        chk("R12 reset xfer_en", xfer_en, 0);
        chk("R12 reset burst_req", burst_req, 0);
        chk("R12 reset frame_done", frame_done, 0);
        chk("R12 reset level", fifo_level, 0);
        pop_one();
        chk("R12 read on empty ignored", fifo_level, 0);
    endtask

    task automatic t_unicast();
        burst_thresh = LW'(8);
        for (int k = 0; k < 6; k++) fr[k] = station_addr[8*k +: 8];
        for (int k = 6; k < 12; k++) fr[k] = 8'(8'h10 + k);
        fr[12] = 8'h00; fr[13] = 8'h00; fr[14] = 8'hD5; fr[15] = 8'h3C;
        open_frame();
        for (int k = 0; k < 16; k++) begin
            send_octet(fr[k]);
            chk("R3 level per octet", fifo_level, k + 1);
            chk("R8 frame stays open", frame_valid, 1);
            if (k < 5) begin
                chk("R4 xfer held in address", xfer_en, 0);
                chk("R4 burst held in address", burst_req, 0);
            end else begin
                chk("R5 R7 unicast match enables xfer", xfer_en, 1);
                chk("R5 burst at threshold", burst_req, (k + 1) >= 8);
            end
        end
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, 1'b1);
        chk("R9 partial octet discarded", fifo_level, 16);
        end_carrier();
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk("R3 R8 octet content", rd_data, fr[k]);
            chk("R10 drain burst while not empty", burst_req, 1);
            pop_one();
        end
        chk("R10 fifo drained", fifo_level, 0);
        chk("R10 burst off when empty", burst_req, 0);
        chk("R10 xfer kept after frame", xfer_en, 1);
    endtask

    task automatic t_broadcast();
        burst_thresh = LW'(4);
        for (int k = 0; k < 6; k++) fr[k] = 8'hFF;
        for (int k = 6; k < 14; k++) fr[k] = 8'(8'hA0 + k);
        open_frame();
        for (int k = 0; k < 14; k++) begin
            send_octet(fr[k]);
            chk("R5 broadcast level", fifo_level, k + 1);
            if (k >= 5) begin
                chk("R7 broadcast accepted", xfer_en, 1);
                chk("R5 burst at low threshold", burst_req, 1);
            end
        end
        end_carrier();
        chk("R2 leftover kept until next frame", fifo_level, 14);
    endtask

    task automatic t_mismatch();
        burst_thresh = LW'(4);
        for (int k = 0; k < 6; k++) fr[k] = station_addr[8*k +: 8];
        fr[5] = fr[5] ^ 8'h01;
        open_frame();
        for (int k = 0; k < 6; k++) begin
            send_octet(fr[k]);
            if (k < 5) chk("R6 address octets stored", fifo_level, k + 1);
        end
        chk("R6 R7 last octet mismatch flushes", fifo_level, 0);
        chk("R6 xfer stays low", xfer_en, 0);
        for (int k = 0; k < 6; k++) begin
            send_octet(8'h5A);
            chk("R6 no fill after mismatch", fifo_level, 0);
            chk("R6 burst stays low", burst_req, 0);
        end
        end_carrier();
        chk("R6 xfer low after rejected frame", xfer_en, 0);
    endtask

    task automatic t_short();
        send_preamble(16);
        chk("R11 no frame in preamble", frame_valid, 0);
        for (int i = 0; i < 5; i++) begin
            bit_cycle(1'b0, 1'b0);
            chk("R11 aborted preamble no done", frame_done, 0);
            chk("R11 aborted preamble no frame", frame_valid, 0);
        end
        open_frame();
        for (int k = 0; k < 3; k++) begin
            send_octet(station_addr[8*k +: 8]);
            chk("R11 truncated address holds xfer", xfer_en, 0);
        end
        end_carrier();
        chk("R11 xfer never rises", xfer_en, 0);
        chk("R11 truncated octets kept", fifo_level, 3);
    endtask

    initial begin
        t_reset();
        t_unicast();
        t_broadcast();
        t_mismatch();
        t_short();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule